// File: doc/BRIEF.md
# Prioritized Interrupt Distributor

This block collects up to 64 interrupt inputs and routes them to up to 8 processor cores. A distributor half keeps, for every interrupt ID, an enable bit, a pending bit, an edge/level trigger selection, an 8-bit priority and a mask of target cores. A per-core interface half keeps an enable bit, a priority mask and a binary-point value. It raises that core's interrupt line when the most urgent eligible interrupt passes the mask and is allowed to preempt whatever the core is already servicing.

Software reaches every register through one 32-bit word-addressed port. A core takes an interrupt by reading its acknowledge register. The read returns the ID and marks that ID active. The core finishes by writing the ID to its end-of-interrupt register. Smaller priority numbers are more urgent, and equal priorities go to the lower ID.

Byte addresses (13 bits) are laid out as follows. Distributor control is at 0x000. The enable, pending and trigger banks are at 0x100/0x180/0x200/0x280/0x300, each with one word per 32 IDs. Priorities are at 0x400+4·ID and target masks at 0x600+4·ID. Core c has its interface at 0x1000+0x100·c.

Top module: `prio_irq_dist`

## Requirements
- R1: After reset every interrupt line is low, all enables, pending bits, priorities, targets, masks and control bits read 0, and an acknowledge read returns 1023.
- R2: A core's line can rise only while bit 0 of distributor control (0x000) and bit 0 of that core's interface control (offset 0x0) are both 1.
- R3: Writing 1 to bit ID mod 32 of word ID/32 at 0x100 sets that enable, and writing 1 at 0x180 clears it. Zero bits have no effect, and either address reads back the enable word.
- R4: For an ID whose trigger bit at 0x300 is 1 (edge), a rising input sets pending. A 1 written at 0x200 also sets it, and a 1 at 0x280 clears it. Reading 0x200 returns the pending word.
- R5: For an ID whose trigger bit is 0 (level), pending equals the input as sampled on the previous clock, and writes to the pending banks do not change it.
- R6: An interrupt is signalled to a core only if its priority byte is numerically below that core's mask (interface offset 0x4).
- R7: Among enabled, pending, inactive IDs whose target mask has the core's bit set, the lowest priority value wins, and the lower ID wins a tie.
- R8: A read at interface offset 0xC returns the winning ID, marks it active and clears its edge pending bit. If no interrupt would be signalled, the read returns 1023.
- R9: Writing an ID to interface offset 0x10 clears that core's active mark for it.
- R10: While a core has active IDs, a new one is signalled only if its group priority is strictly below the most urgent active group priority. The group priority is the priority with its low B bits cleared, where B is the 3-bit binary point at interface offset 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IDS | Interrupt source inputs, one per ID |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 13 | Byte address of the accessed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| rvalid | output | 1 | Read data valid |
| irq_out | output | NUM_CORES | Registered interrupt line per core |

## Verification
The priority mask is swept over all 256 values against one pending interrupt. This locates the strict-less-than boundary exactly. Several IDs are then made pending with equal and different priorities on two cores, and a chain of acknowledges and end-of-interrupt writes separates priority order, the lower-ID tie rule, target filtering and the return of 1023. Preemption is tried with one pair of priorities under two binary points, one that keeps them in separate groups and one that merges them, so group masking is told apart from plain comparison. Edge and level IDs receive the same pending-bank writes while their inputs are held, which shows which trigger mode those writes act on.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int PRIO_W = 8;
  localparam logic [31:0] NONE_ID = 32'd1023;

  // priority with the sub-group bits removed
  function automatic logic [PRIO_W-1:0] group_of(input logic [PRIO_W-1:0] p,
                                                  input logic [2:0] bp);
    return p & (8'hFF << bp);
  endfunction
endpackage

// File: rtl/pid_pend.sv
module pid_pend #(
  parameter int NUM_IDS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDS-1:0] irq_in,
  input  logic [NUM_IDS-1:0] cfg_edge,
  input  logic [NUM_IDS-1:0] set_m,
  input  logic [NUM_IDS-1:0] clr_m,
  output logic [NUM_IDS-1:0] pend
);
  logic [NUM_IDS-1:0] irq_q;
  logic [NUM_IDS-1:0] rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_in;
      for (int i = 0; i < NUM_IDS; i++) begin
        if (cfg_edge[i])
          pend[i] <= (pend[i] & ~clr_m[i]) | rise[i] | set_m[i];
        else
          pend[i] <= irq_in[i];
      end
    end
  end
endmodule

// File: rtl/pid_arb.sv
module pid_arb
  import pid_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int ID_W    = 6
) (
  input  logic [NUM_IDS-1:0]             cand,
  input  logic [NUM_IDS-1:0]             act,
  input  logic [NUM_IDS-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]              pmr,
  input  logic [2:0]                     bpr,
  output logic [ID_W-1:0]                best_id,
  output logic [PRIO_W-1:0]              best_prio,
  output logic                           hit
);
  logic              found;
  logic              has_act;
  logic [PRIO_W-1:0] run_p;

  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    has_act   = 1'b0;
    run_p     = '1;
    for (int i = 0; i < NUM_IDS; i++) begin
      // strict compare keeps the lower ID on a tie
      if (cand[i] && (!found || prio[i] < best_prio)) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio[i];
      end
      if (act[i]) begin
        has_act = 1'b1;
        if (prio[i] < run_p) run_p = prio[i];
      end
    end
    hit = found && (best_prio < pmr) &&
          (!has_act || group_of(best_prio, bpr) < group_of(run_p, bpr));
  end
endmodule

// File: rtl/prio_irq_dist.sv
module prio_irq_dist
  import pid_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int NUM_CORES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_IDS-1:0]   irq_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [12:0]          addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 rvalid,
  output logic [NUM_CORES-1:0] irq_out
);
  localparam int ID_W   = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  // state
  logic                                dist_en;
  logic [NUM_IDS-1:0]                  en_q;
  logic [NUM_IDS-1:0]                  cfg_q;
  logic [NUM_IDS-1:0][PRIO_W-1:0]      prio_q;
  logic [NUM_IDS-1:0][NUM_CORES-1:0]   tgt_q;
  logic [NUM_CORES-1:0]                cpu_en;
  logic [NUM_CORES-1:0][PRIO_W-1:0]    pmr_q;
  logic [NUM_CORES-1:0][2:0]           bpr_q;
  logic [NUM_CORES-1:0][NUM_IDS-1:0]   act_q;
  logic [NUM_IDS-1:0]                  pend;

  // decode
  logic              is_cpu;
  logic [2:0]        core_sel;
  logic [7:0]        coff;
  logic [4:0]        dblk;
  logic [4:0]        dword;
  logic [5:0]        didx;
  logic              core_ok;
  logic              idx_ok;
  logic [CORE_W-1:0] ci;
  logic [ID_W-1:0]   di;

  assign is_cpu   = addr[12];
  assign core_sel = addr[10:8];
  assign coff     = addr[7:0];
  assign dblk     = addr[11:7];
  assign dword    = addr[6:2];
  assign didx     = addr[7:2];
  assign core_ok  = int'(core_sel) < NUM_CORES;
  assign idx_ok   = int'(didx) < NUM_IDS;
  assign ci       = CORE_W'(core_sel);
  assign di       = ID_W'(didx);

  logic [NUM_IDS-1:0] set_en_m, clr_en_m, set_pd_m, clr_pd_m, cfg_wr_m, ack_clr;
  logic [NUM_IDS-1:0] act_any;
  logic [NUM_CORES-1:0][NUM_IDS-1:0] cand;
  logic [NUM_CORES-1:0][ID_W-1:0]    best_id_w;
  logic [NUM_CORES-1:0][PRIO_W-1:0]  best_prio_w;
  logic [NUM_CORES-1:0]              hit_w;
  logic                              ack_ok;
  logic                              ack_fire;
  logic [31:0]                       rd_mux;

  always_comb begin
    set_en_m = '0;
    clr_en_m = '0;
    set_pd_m = '0;
    clr_pd_m = '0;
    cfg_wr_m = '0;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (wr_en && !is_cpu && int'(dword) == i / 32) begin
        case (dblk)
          5'd2: set_en_m[i] = wdata[i % 32];
          5'd3: clr_en_m[i] = wdata[i % 32];
          5'd4: set_pd_m[i] = wdata[i % 32];
          5'd5: clr_pd_m[i] = wdata[i % 32];
          5'd6: cfg_wr_m[i] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    act_any = '0;
    for (int c = 0; c < NUM_CORES; c++) act_any = act_any | act_q[c];
  end

  pid_pend #(.NUM_IDS(NUM_IDS)) i_pend (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .cfg_edge (cfg_q),
    .set_m    (set_pd_m),
    .clr_m    (clr_pd_m | ack_clr),
    .pend     (pend)
  );

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      always_comb begin
        for (int i = 0; i < NUM_IDS; i++)
          cand[c][i] = dist_en & en_q[i] & pend[i] & ~act_any[i] & tgt_q[i][c];
      end
      pid_arb #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) i_arb (
        .cand      (cand[c]),
        .act       (act_q[c]),
        .prio      (prio_q),
        .pmr       (pmr_q[c]),
        .bpr       (bpr_q[c]),
        .best_id   (best_id_w[c]),
        .best_prio (best_prio_w[c]),
        .hit       (hit_w[c])
      );
    end
  endgenerate

  assign ack_ok   = core_ok && hit_w[ci] && cpu_en[ci];
  assign ack_fire = rd_en && is_cpu && coff == 8'h0C && ack_ok;

  always_comb begin
    ack_clr = '0;
    for (int i = 0; i < NUM_IDS; i++)
      if (ack_fire && int'(best_id_w[ci]) == i) ack_clr[i] = 1'b1;
  end

  function automatic logic [31:0] word_of(input logic [NUM_IDS-1:0] v,
                                          input logic [4:0] w);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++)
      if (int'(w) * 32 + b < NUM_IDS) r[b] = v[int'(w) * 32 + b];
    return r;
  endfunction

  always_comb begin
    rd_mux = '0;
    if (is_cpu) begin
      if (core_ok) begin
        case (coff)
          8'h00: rd_mux = {31'd0, cpu_en[ci]};
          8'h04: rd_mux = {24'd0, pmr_q[ci]};
          8'h08: rd_mux = {29'd0, bpr_q[ci]};
          8'h0C: rd_mux = ack_ok ? 32'(best_id_w[ci]) : NONE_ID;
          default: ;
        endcase
      end
    end else if (addr[11:0] == 12'h000) begin
      rd_mux = {31'd0, dist_en};
    end else if (addr[11:8] == 4'h4) begin
      if (idx_ok) rd_mux = {24'd0, prio_q[di]};
    end else if (addr[11:8] == 4'h6) begin
      if (idx_ok) rd_mux = 32'(tgt_q[di]);
    end else begin
      case (dblk)
        5'd2, 5'd3: rd_mux = word_of(en_q, dword);
        5'd4, 5'd5: rd_mux = word_of(pend, dword);
        5'd6:       rd_mux = word_of(cfg_q, dword);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_en <= 1'b0;
      en_q    <= '0;
      cfg_q   <= '0;
      prio_q  <= '0;
      tgt_q   <= '0;
      cpu_en  <= '0;
      pmr_q   <= '0;
      bpr_q   <= '0;
      act_q   <= '0;
      irq_out <= '0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      en_q <= (en_q | set_en_m) & ~clr_en_m;
      for (int i = 0; i < NUM_IDS; i++)
        if (cfg_wr_m[i]) cfg_q[i] <= wdata[i % 32];
      if (wr_en && !is_cpu) begin
        if (addr[11:0] == 12'h000) dist_en <= wdata[0];
        if (addr[11:8] == 4'h4 && idx_ok) prio_q[di] <= wdata[PRIO_W-1:0];
        if (addr[11:8] == 4'h6 && idx_ok) tgt_q[di] <= wdata[NUM_CORES-1:0];
      end
      if (wr_en && is_cpu && core_ok) begin
        case (coff)
          8'h00: cpu_en[ci] <= wdata[0];
          8'h04: pmr_q[ci]  <= wdata[PRIO_W-1:0];
          8'h08: bpr_q[ci]  <= wdata[2:0];
          8'h10: if (int'(wdata[9:0]) < NUM_IDS) act_q[ci][ID_W'(wdata[9:0])] <= 1'b0;
          default: ;
        endcase
      end
      if (ack_fire) act_q[ci][best_id_w[ci]] <= 1'b1;
      irq_out <= cpu_en & hit_w;
      rvalid  <= rd_en;
      rdata   <= rd_mux;
    end
  end
endmodule

// File: rtl/pid_chk.sv
module pid_chk #(
  parameter int NUM_IDS   = 64,
  parameter int NUM_CORES = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           dist_en,
  input logic [NUM_CORES-1:0]           cpu_en,
  input logic [NUM_CORES-1:0]           irq_out,
  input logic [NUM_CORES-1:0][7:0]      pmr,
  input logic [NUM_CORES-1:0][7:0]      best_prio,
  input logic [NUM_IDS-1:0]             irq_in,
  input logic [NUM_IDS-1:0]             cfg_edge,
  input logic [NUM_IDS-1:0]             pend
);
  logic [NUM_IDS-1:0] seen_q;
  logic [NUM_IDS-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else     seen_q <= irq_in;
  end
  assign rise = irq_in & ~seen_q & cfg_edge;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq_out == '0);

  a_r4_edge_sets_pending: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> (pend & $past(rise)) == $past(rise));

  a_r5_level_tracks_input: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~$past(cfg_edge)) & (pend ^ $past(irq_in))) == '0);

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
      a_r2_needs_both_enables: assert property (@(posedge clk) disable iff (rst)
        irq_out[c] |-> $past(dist_en && cpu_en[c]));
      a_r6_below_mask: assert property (@(posedge clk) disable iff (rst)
        irq_out[c] |-> $past(best_prio[c] < pmr[c]));
    end
  endgenerate
endmodule

bind prio_irq_dist pid_chk #(.NUM_IDS(NUM_IDS), .NUM_CORES(NUM_CORES)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .dist_en   (dist_en),
  .cpu_en    (cpu_en),
  .irq_out   (irq_out),
  .pmr       (pmr_q),
  .best_prio (best_prio_w),
  .irq_in    (irq_in),
  .cfg_edge  (cfg_q),
  .pend      (pend)
);

// File: tb/test_prio_irq_dist.sv
module test_prio_irq_dist;
  localparam int NI = 64;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] irq_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [12:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [NC-1:0] irq_out;

  int total = 0;
  int bad = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  prio_irq_dist #(.NUM_IDS(NI), .NUM_CORES(NC)) i_prio_irq_dist (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq_out(irq_out)
  );

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [12:0] cpu(input int c, input int off);
    return 13'(32'h1000 + c * 32'h100 + off);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_out", 32'(irq_out), 32'd0);
    rd(13'h000, v); chk("R1 dist ctrl", v, 0);
    rd(cpu(0, 4), v); chk("R1 mask", v, 0);
    rd(13'h100, v); chk("R1 enable word", v, 0);
    rd(13'h408, v); chk("R1 priority", v, 0);
    rd(cpu(0, 12), v); chk("R1 ack none", v, 1023);

    // R3 enable banks
    wr(13'h100, 32'h5); rd(13'h100, v); chk("R3 set", v, 32'h5);
    wr(13'h100, 32'h0); rd(13'h180, v); chk("R3 zero write ignored", v, 32'h5);
    wr(13'h180, 32'h1); rd(13'h100, v); chk("R3 clear", v, 32'h4);
    wr(13'h104, 32'h8); rd(13'h104, v); chk("R3 upper word ID35", v, 32'h8);
    wr(13'h180, 32'hFFFF_FFFF); wr(13'h184, 32'hFFFF_FFFF);
    rd(13'h104, v); chk("R3 cleared all", v, 0);

    // R4 edge pending
    wr(13'h300, 32'hFFFF_FFFF); wr(13'h304, 32'hFFFF_FFFF);
    irq_in[7] = 1'b1; settle();
    rd(13'h200, v); chk("R4 rising edge", v, 32'h80);
    wr(13'h280, 32'h80); rd(13'h200, v); chk("R4 clear while held", v, 0);
    irq_in[7] = 1'b0;
    wr(13'h204, 32'h1); rd(13'h204, v); chk("R4 set by write ID32", v, 32'h1);
    wr(13'h284, 32'h1); rd(13'h204, v); chk("R4 clear ID32", v, 0);

    // R5 level pending
    wr(13'h300, ~32'h200);
    irq_in[9] = 1'b1; settle();
    rd(13'h200, v); chk("R5 level high", v, 32'h200);
    wr(13'h280, 32'h200); rd(13'h200, v); chk("R5 clear ignored", v, 32'h200);
    irq_in[9] = 1'b0; settle();
    rd(13'h200, v); chk("R5 level low", v, 0);
    wr(13'h200, 32'h200); rd(13'h200, v); chk("R5 set ignored", v, 0);
    wr(13'h300, 32'hFFFF_FFFF);

    // R2 enables: ID3 priority 0x10, core0 target, pending
    wr(13'h40C, 32'h10); wr(13'h60C, 32'h1);
    wr(13'h100, 32'h8); wr(13'h200, 32'h8);
    wr(cpu(0, 4), 32'hFF); settle();
    chk("R2 both off", 32'(irq_out), 0);
    wr(13'h000, 1); settle();
    chk("R2 dist only", 32'(irq_out), 0);
    wr(13'h000, 0); wr(cpu(0, 0), 1); settle();
    chk("R2 cpu only", 32'(irq_out), 0);
    wr(13'h000, 1); settle();
    chk("R2 both on", 32'(irq_out), 1);

    // R6 full mask sweep against priority 0x10
    for (int p = 0; p < 256; p++) begin
      wr(cpu(0, 4), 32'(p)); settle();
      chk("R6 mask sweep", 32'(irq_out[0]), (p > 16) ? 1 : 0);
    end
    wr(cpu(0, 4), 32'hFF);

    // R7 selection: IDs 20 and 40 at 0x08, ID50 at 0x00 for core1 only
    wr(13'h450, 32'h08); wr(13'h650, 32'h1);
    wr(13'h4A0, 32'h08); wr(13'h6A0, 32'h1);
    wr(13'h4C8, 32'h00); wr(13'h6C8, 32'h2);
    wr(13'h100, 32'h0010_0008); wr(13'h104, 32'h0004_0100);
    wr(13'h200, 32'h0010_0000); wr(13'h204, 32'h0004_0100);
    rd(cpu(0, 12), v); chk("R7 tie lower ID, target filter", v, 20);
    rd(13'h200, v); chk("R8 ack clears pending", v & 32'h0010_0000, 0);
    rd(cpu(0, 12), v); chk("R10 equal priority no preempt", v, 1023);
    wr(cpu(0, 16), 20);
    rd(cpu(0, 12), v); chk("R9 eoi frees next", v, 40);
    wr(cpu(0, 16), 40);
    rd(cpu(0, 12), v); chk("R7 lower urgency last", v, 3);
    wr(cpu(0, 16), 3); settle();
    chk("R8 line low when empty", 32'(irq_out[0]), 0);
    rd(cpu(0, 12), v); chk("R8 ack empty", v, 1023);
    wr(cpu(1, 4), 32'hFF); wr(cpu(1, 0), 1); settle();
    chk("R7 core1 line", 32'(irq_out[1]), 1);
    rd(cpu(1, 12), v); chk("R7 core1 ack", v, 50);
    wr(cpu(1, 16), 50);

    // R10 preemption: ID5 at 0x2F active, ID6 at 0x20 arrives
    wr(13'h414, 32'h2F); wr(13'h614, 32'h1);
    wr(13'h418, 32'h20); wr(13'h618, 32'h1);
    wr(13'h100, 32'h60); wr(13'h200, 32'h20);
    rd(cpu(0, 12), v); chk("R8 ack ID5", v, 5);
    wr(cpu(0, 8), 4); wr(13'h200, 32'h40); settle();
    chk("R10 same group blocked", 32'(irq_out[0]), 0);
    rd(cpu(0, 12), v); chk("R10 same group ack", v, 1023);
    wr(cpu(0, 8), 0); settle();
    chk("R10 finer group preempts", 32'(irq_out[0]), 1);
    rd(cpu(0, 12), v); chk("R10 preempt ack", v, 6);
    wr(cpu(0, 16), 6); wr(cpu(0, 16), 5); settle();
    chk("R9 all retired", 32'(irq_out), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule